// File: doc/BRIEF.md
# Optical Black Clamp Loop Controller

This block is the digital servo that keeps the black level of an image sensor front end at a chosen value. Each line of a sensor has a run of shielded dark pixels, and a clamp strobe marks that run. While the strobe is active, the block subtracts a programmable 8-bit black target from every valid ADC sample and adds the result into an error sum. When the strobe ends, a scaled copy of that sum is taken off an 8-bit correction code. That code drives an offset DAC placed ahead of the converter. Outside the strobe the code does not move, so a line whose strobe is missing leaves the offset unchanged.

The accumulation acts as the noise filter. Summing over the window and then shifting right by `GAIN_SHIFT` sets the loop gain, and the sample noise is averaged down before the DAC code changes. When the loop enable is low, the servo stops. The DAC code then follows the black-target register, so that register still works as a fixed offset. The strobe's active level can be selected, so the strobe source may be active high or active low.

Top module: `ob_clamp_servo`

## Requirements
- R1: A synchronous active-high reset sets `dac_code_o` to the midscale code 128, and the code stays at 128 in the first cycle after reset.
- R2: The strobe is active when `clamp_strobe_i` equals `strobe_pol_i` (1 = active high, 0 = active low). The active level has the same effect under either polarity.
- R3: A sample enters the error sum only in a cycle where the strobe is active, `sample_vld_i` is 1 and the loop is enabled. Samples with `sample_vld_i` low have no effect on the resulting code.
- R4: While the loop is enabled, `dac_code_o` changes only in the cycle after the strobe goes from active to inactive. It holds during the window and between windows.
- R5: At the end of a window the new code is the old code minus (S >>> `GAIN_SHIFT`). S is the signed sum of (sample − target) over the window. The shift is arithmetic and rounds toward minus infinity, so a sum of −3 with a shift of 2 raises the code by 1.
- R6: The new code saturates at 0 and at 255 and never wraps.
- R7: While `loop_en_i` is 0, `dac_code_o` equals the value `black_target_i` had one cycle earlier, and strobes have no effect.
- R8: Every window starts from an empty sum. Idle time of any length between windows, including valid samples outside strobes, does not change the code.
- R9: When the loop is enabled again, it continues from the static offset that was last applied, that is, from the black target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample_i | input | ADC_W | Unsigned converter output sample |
| sample_vld_i | input | 1 | Sample qualifier |
| clamp_strobe_i | input | 1 | Raw dark-pixel clamp strobe |
| strobe_pol_i | input | 1 | Active level of the clamp strobe (1 = high) |
| black_target_i | input | 8 | Black-level target in converter LSBs; static offset when the loop is disabled |
| loop_en_i | input | 1 | Loop enable |
| dac_code_o | output | 8 | Registered offset DAC code |

## Verification
The behaviour that is hardest to reach from the ports is the floor rounding of a small negative sum. A plant that feeds the DAC code back into the samples normally produces large errors. To reach it, the bench first steers the loop so that it settles exactly: with a four-sample window and a shift of 2, the loop gain is one, and the code converges in one step. It then places the pixel level so that a single-sample window gives an error of −3. Both saturation limits are reached with long windows under large errors of opposite sign. Each window's expected code comes from the bench's own arithmetic on the samples it drove.

// File: rtl/obc_pkg.sv
package obc_pkg;
  localparam int CODE_W   = 8;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int CODE_MID = 1 << (CODE_W - 1);
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/obc_strobe_cond.sv
module obc_strobe_cond (
  input  logic clk,
  input  logic rst,
  input  logic strobe_raw_i,
  input  logic pol_i,
  output logic active_o,
  output logic fall_o
);
  logic active_q;

  assign active_o = strobe_raw_i ~^ pol_i;
  assign fall_o   = active_q & ~active_o;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= active_o;
  end

  // R5: one window end produces exactly one update pulse
  p_single_update_r5: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/obc_err_accum.sv
module obc_err_accum #(
  parameter int ADC_W    = 10,
  parameter int WIN_LOG2 = 10,
  localparam int ACC_W   = ADC_W + 1 + WIN_LOG2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    strb_i,
  input  logic                    fall_i,
  input  logic                    vld_i,
  input  logic [ADC_W-1:0]        sample_i,
  input  obc_pkg::code_t          target_i,
  output logic signed [ACC_W-1:0] acc_o
);
  import obc_pkg::*;
  localparam int ERR_W = ADC_W + 1;

  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W-1:0] acc_q;

  assign err   = $signed({1'b0, sample_i}) - $signed({{(ERR_W-CODE_W){1'b0}}, target_i});
  assign acc_o = acc_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || fall_i)
      acc_q <= '0;
    else if (strb_i && vld_i)
      acc_q <= acc_q + {{WIN_LOG2{err[ERR_W-1]}}, err};
  end

  // R8: each window end empties the sum
  p_window_clear_r8: assert property (@(posedge clk) disable iff (rst)
    fall_i |=> acc_q == '0);
  // R3: no accumulation without an active strobe and a valid sample
  p_gated_sum_r3: assert property (@(posedge clk) disable iff (rst)
    en_i && !fall_i && !(strb_i && vld_i) |=> $stable(acc_q));
endmodule

// File: rtl/obc_corr_reg.sv
module obc_corr_reg #(
  parameter int          ACC_W      = 21,
  parameter logic [2:0]  GAIN_SHIFT = 3'd2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    fall_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  obc_pkg::code_t          target_i,
  output obc_pkg::code_t          corr_o
);
  import obc_pkg::*;
  localparam int NW = ACC_W + 1;
  localparam logic signed [NW-1:0] TOP = NW'(CODE_MAX);

  code_t                   corr_q;
  logic signed [ACC_W-1:0] step;
  logic signed [NW-1:0]    nxt;
  code_t                   sat;

  assign step = acc_i >>> GAIN_SHIFT;
  assign nxt  = $signed({{(NW-CODE_W){1'b0}}, corr_q}) - $signed({step[ACC_W-1], step});

  always_comb begin
    if (nxt < 0)        sat = '0;
    else if (nxt > TOP) sat = code_t'(CODE_MAX);
    else                sat = nxt[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         corr_q <= code_t'(CODE_MID);
    else if (!en_i)  corr_q <= target_i;
    else if (fall_i) corr_q <= sat;
  end

  assign corr_o = corr_q;

  // R4: the code only moves at a window end while enabled
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    en_i && !fall_i |=> corr_q == $past(corr_q));
  // R7: disabled loop applies the target as a static offset
  p_static_r7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> corr_q == $past(target_i));
  // R6: a positive sum never raises the code (no wrap past 0)
  p_no_wrap_dn_r6: assert property (@(posedge clk) disable iff (rst)
    en_i && fall_i && acc_i > 0 |=> corr_q <= $past(corr_q));
  // R6: a negative sum never lowers the code (no wrap past 255)
  p_no_wrap_up_r6: assert property (@(posedge clk) disable iff (rst)
    en_i && fall_i && acc_i < 0 |=> corr_q >= $past(corr_q));
endmodule

// File: rtl/ob_clamp_servo.sv
module ob_clamp_servo #(
  parameter int         ADC_W      = 10,
  parameter int         WIN_LOG2   = 10,
  parameter logic [2:0] GAIN_SHIFT = 3'd2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADC_W-1:0] adc_sample_i,
  input  logic             sample_vld_i,
  input  logic             clamp_strobe_i,
  input  logic             strobe_pol_i,
  input  logic [7:0]       black_target_i,
  input  logic             loop_en_i,
  output logic [7:0]       dac_code_o
);
  import obc_pkg::*;
  localparam int ACC_W = ADC_W + 1 + WIN_LOG2;

  logic                    strb;
  logic                    fall;
  logic signed [ACC_W-1:0] acc;
  code_t                   corr;

  obc_strobe_cond u_strb (
    .clk          (clk),
    .rst          (rst),
    .strobe_raw_i (clamp_strobe_i),
    .pol_i        (strobe_pol_i),
    .active_o     (strb),
    .fall_o       (fall)
  );

  obc_err_accum #(.ADC_W(ADC_W), .WIN_LOG2(WIN_LOG2)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .en_i     (loop_en_i),
    .strb_i   (strb),
    .fall_i   (fall),
    .vld_i    (sample_vld_i),
    .sample_i (adc_sample_i),
    .target_i (black_target_i),
    .acc_o    (acc)
  );

  obc_corr_reg #(.ACC_W(ACC_W), .GAIN_SHIFT(GAIN_SHIFT)) u_corr (
    .clk      (clk),
    .rst      (rst),
    .en_i     (loop_en_i),
    .fall_i   (fall),
    .acc_i    (acc),
    .target_i (black_target_i),
    .corr_o   (corr)
  );

  assign dac_code_o = corr;

  // R1: reset lands on midscale
  p_reset_mid_r1: assert property (@(posedge clk)
    rst |=> dac_code_o == 8'd128);
endmodule

// File: tb/ob_clamp_servo_tb_top.sv
module ob_clamp_servo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADC_W      = 10;
  localparam int SHIFT      = 2;
  localparam int ADC_MAX    = (1 << ADC_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [ADC_W-1:0] adc = '0;
  logic             vld = 1'b0;
  logic             strobe = 1'b0;
  logic             pol = 1'b1;
  logic [7:0]       target = 8'd64;
  logic             en = 1'b1;
  logic [7:0]       dac;

  int n_run = 0;
  int n_fail = 0;
  int exp_code = 128;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ob_clamp_servo #(.ADC_W(ADC_W), .WIN_LOG2(10), .GAIN_SHIFT(3'(SHIFT))) dut_i (
    .clk(clk), .rst(rst), .adc_sample_i(adc), .sample_vld_i(vld),
    .clamp_strobe_i(strobe), .strobe_pol_i(pol), .black_target_i(target),
    .loop_en_i(en), .dac_code_o(dac)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int plant(input int pix);
    int s = pix + int'(dac);
    return (s > ADC_MAX) ? ADC_MAX : s;
  endfunction

  function automatic int sat(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  // one clamp window of n cycles; alt_vld drops every second sample
  task automatic window(input int n, input int pix, input bit alt_vld, input string req);
    int sum = 0;
    bit hold_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe = pol;
      vld = alt_vld ? (i % 2 == 0) : 1'b1;
      adc = ADC_W'(plant(pix));
      if (vld) sum += int'(adc) - int'(target);
      @(posedge clk); #1;
      if (dac != 8'(exp_code)) hold_ok = 1'b0;
    end
    check(hold_ok, "R4 code held inside window", dac, exp_code);
    @(negedge clk);
    strobe = ~pol; vld = 1'b0;
    @(posedge clk); #1;
    exp_code = sat(exp_code - (sum >>> SHIFT));
    check(dac == 8'(exp_code), req, dac, exp_code);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    exp_code = 128;
    check(dac == 8'd128, "R1 reset midscale", dac, 128);
  endtask

  task automatic t_converge;
    target = 8'd64;
    window(4, 40, 1'b0, "R5 first window step");
    window(4, 40, 1'b0, "R5 settled at target");
    check(dac == 8'd24, "R5 converged code", dac, 24);
  endtask

  task automatic t_sparse_valid;
    window(8, 50, 1'b1, "R3 invalid samples ignored");
  endtask

  task automatic t_floor;
    window(1, 61 - int'(dac), 1'b0, "R5 floor rounding of -3");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      strobe = ~pol; vld = 1'b1; adc = ADC_W'((i * 37) % ADC_MAX);
    end
    @(negedge clk); vld = 1'b0;
    @(posedge clk); #1;
    check(dac == 8'(exp_code), "R8 idle samples do not move code", dac, exp_code);
    window(4, 30, 1'b0, "R8 window after long gap");
  endtask

  task automatic t_saturate;
    target = 8'd200;
    window(16, 0, 1'b0, "R6 saturate high");
    check(dac == 8'd255, "R6 top limit", dac, 255);
    target = 8'd10;
    window(16, 900, 1'b0, "R6 saturate low");
    check(dac == 8'd0, "R6 bottom limit", dac, 0);
  endtask

  task automatic t_polarity;
    @(negedge clk); pol = 1'b0; strobe = 1'b1;
    target = 8'd64;
    window(4, 40, 1'b0, "R2 active-low strobe");
    window(4, 44, 1'b0, "R2 active-low second window");
    @(negedge clk); pol = 1'b1; strobe = 1'b0;
  endtask

  task automatic t_disable;
    @(negedge clk); en = 1'b0; target = 8'd77;
    @(posedge clk); #1;
    check(dac == 8'd77, "R7 static offset", dac, 77);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); strobe = 1'b1; vld = 1'b1; adc = 10'd900;
    end
    @(negedge clk); strobe = 1'b0; vld = 1'b0;
    @(posedge clk); #1;
    check(dac == 8'd77, "R7 strobes ignored while disabled", dac, 77);
    @(negedge clk); target = 8'd90;
    @(posedge clk); #1;
    check(dac == 8'd90, "R7 follows target", dac, 90);
    @(negedge clk); en = 1'b1;
    exp_code = 90;
    @(posedge clk); #1;
    check(dac == 8'd90, "R9 resume from static offset", dac, 90);
    target = 8'd100;
    window(4, 20, 1'b0, "R9 first window after enable");
  endtask

  initial begin
    t_reset;
    t_converge;
    t_sparse_valid;
    t_floor;
    t_idle;
    t_saturate;
    t_polarity;
    t_disable;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule